// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block is the master side of a narrow peripheral bus on which address and data share one set of lines. It runs in the host clock domain. It takes a single register-style request and turns it into a sequence of bus cycles. The request carries a 16-bit target address, a direction, a byte count from 1 to 4 and a 32-bit data word. Every sequence opens with an address phase: ALE is high for one cycle and the address is then held for a second cycle, so the target latches the address on the falling edge of ALE. The data phases follow. A data phase is a read or write strobe whose width is set by a programmable cycle timer.

Two sequencing styles are available. In the shared-address style, one address phase serves every byte, and the strobes are separated by a short recovery gap. In the incremental style, each byte gets its own address phase, and a direction-dependent idle time comes before each new address phase. The controller can also stretch a strobe with a ready input from the target, which is not synchronous to the host clock. The timer then acts as a ready-wait window. When the window runs out, one strobe mode keeps waiting and the other forces the cycle to end, so a hung target cannot hold the bus. Requests that would cross a 32-bit boundary are refused and flagged.

Top module: `mxbus_cycle_ctrl`

## Requirements
- R1: After reset, ale=0, rd_n=1, wr_n=1, ad_oe=0, busy=0, done=0, to_flag=0, fe_flag=0.
- R2: Each address phase is ALE high for exactly one cycle with the address on ad_out[15:0] and ad_oe=1, then one cycle with ALE low and the address still driven. ALE is never high while a strobe is low, and rd_n and wr_n are never low together.
- R3: When ready stretching is off (cfg_use_rdy=0), every strobe stays low for exactly cfg_timeout+1 cycles in both strobe modes, and to_flag is not set.
- R4: In shared-address mode (cfg_incr=0), a transfer has exactly one address phase. Consecutive strobes are separated by 1 high cycle when cfg_fast=1 and by 2 high cycles when cfg_fast=0.
- R5: In incremental mode (cfg_incr=1), byte k has its own address phase carrying req_addr+k. The strobe rises, then rd_n/wr_n stay high for 3 cycles (write) or 4 cycles (read) before the next ALE, whatever cfg_fast is.
- R6: Byte k of a transfer uses bits [8k+7:8k] of the data word, starting at k=0. On a write that byte is driven on ad_out[7:0] with ad_oe=1 while wr_n is low. On a read, ad_oe=0 while rd_n is low, ad_in is captured in the last strobe cycle into rdata[8k+7:8k], and rdata bytes that are not transferred read zero.
- R7: With cfg_use_rdy=1 and cfg_moto=0, rdy_in passes through a two-flop synchronizer. The strobe ends in the first strobe cycle c (counting from 0) with c >= cfg_timeout in which the synchronized ready is high.
- R8: With cfg_use_rdy=1 and cfg_moto=1, if the synchronized ready is still low at strobe cycle c = cfg_timeout, the strobe ends in that cycle (width cfg_timeout+1) and the transfer completes.
- R9: With cfg_use_rdy=1, to_flag is set when the synchronized ready is low at strobe cycle c = cfg_timeout. It stays set until a clr_flags pulse.
- R10: A request is illegal when req_len is 0 or above 4, or when req_addr[1:0]+req_len exceeds 4. An illegal request causes no bus activity and no done, and sets fe_flag, which stays set until clr_flags.
- R11: done is a one-cycle pulse in the cycle after the last strobe cycle. busy is high from the cycle after an accepted start up to and including the done cycle.
- R12: A start pulse that arrives while busy is high is ignored. The running transfer continues unchanged, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| req_addr | input | 16 | Target address of the first byte |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_len | input | 3 | Byte count, legal 1 to 4 |
| req_wdata | input | 32 | Write data word, least significant byte first |
| cfg_timeout | input | TMR_W | Cycle timer value |
| cfg_fast | input | 1 | Short recovery gap in shared-address mode |
| cfg_incr | input | 1 | 1 = address phase before every byte |
| cfg_moto | input | 1 | 1 = timer expiry ends the strobe (forced mode) |
| cfg_use_rdy | input | 1 | Enable ready-based stretching |
| rdy_in | input | 1 | Asynchronous target ready, high = ready |
| ad_in | input | 8 | Read data from the shared bus |
| clr_flags | input | 1 | Clears to_flag and fe_flag |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 16 | Address/data driven onto the shared bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| rdata | output | 32 | Collected read bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete pulse |
| to_flag | output | 1 | Ready-wait timer overflow, sticky |
| fe_flag | output | 1 | Boundary/format error, sticky |

## Verification
The main function is exercised with writes and reads in both sequencing styles, with the recovery setting both on and off and with several timer values. Comparing gap lengths separates the shared-address spacing of 1 or 2 cycles from the incremental idle of 3 or 4 cycles. The logged addresses and bytes show whether the byte order and the address increment are right. For ready stretching, the bench releases ready at chosen strobe cycles. Some release points fall before the timer value and some after, which separates "timer sets a floor" from "timer sets the width". A target that never becomes ready separates the waiting mode from the forced-end mode. Boundary requests at the last legal byte and one byte past it show where the format check rejects.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int MXB_AW     = 16;
    localparam int MXB_DW     = 32;
    localparam int MXB_BYTES  = MXB_DW / 8;
    localparam int MXB_LEN_W  = 3;
    localparam int MXB_LANE_W = $clog2(MXB_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_ADDR,
        ST_STRB,
        ST_GAP,
        ST_FIN
    } mxb_state_e;

    typedef struct packed {
        logic [MXB_AW-1:0]    addr;
        logic                 wr;
        logic [MXB_LEN_W-1:0] len;
        logic [MXB_DW-1:0]    data;
    } mxb_req_t;

    // Number of high cycles after a strobe before the next bus action.
    function automatic logic [2:0] gap_cycles(input logic incr, input logic fast,
                                              input logic wr);
        if (incr)      return wr ? 3'd3 : 3'd4;
        else if (fast) return 3'd1;
        else           return 3'd2;
    endfunction

    // Legal when 1..4 bytes and the run stays inside one 32-bit word.
    function automatic logic span_ok(input logic [MXB_LANE_W-1:0] lane,
                                     input logic [MXB_LEN_W-1:0] len);
        logic [3:0] last;
        last = {{(4-MXB_LANE_W){1'b0}}, lane} + {1'b0, len};
        return (len != '0) && ({1'b0, len} <= 4'(MXB_BYTES)) &&
               (last <= 4'(MXB_BYTES));
    endfunction

endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/mxb_req_check.sv
module mxb_req_check
    import mxb_pkg::*;
(
    input  logic [MXB_LANE_W-1:0] lane,
    input  logic [MXB_LEN_W-1:0]  len,
    output logic                  legal
);
    always_comb legal = span_ok(lane, len);
endmodule

// File: rtl/mxb_strobe_timer.sv
module mxb_strobe_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [TMR_W-1:0] limit,
    input  logic             use_rdy,
    input  logic             forced,
    input  logic             rdy_s,
    output logic             strb_last,
    output logic             ovf_evt
);
    logic [TMR_W-1:0] cnt;
    logic             expired;

    always_ff @(posedge clk) begin
        if (rst || !active)   cnt <= '0;
        else if (cnt != '1)   cnt <= cnt + 1'b1;
    end

    always_comb begin
        expired   = (cnt >= limit);
        strb_last = active && expired && (!use_rdy || rdy_s || forced);
        ovf_evt   = active && use_rdy && (cnt == limit) && !rdy_s;
    end
endmodule

// File: rtl/mxbus_cycle_ctrl.sv
module mxbus_cycle_ctrl
    import mxb_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MXB_AW-1:0]    req_addr,
    input  logic                 req_wr,
    input  logic [MXB_LEN_W-1:0] req_len,
    input  logic [MXB_DW-1:0]    req_wdata,
    input  logic [TMR_W-1:0]     cfg_timeout,
    input  logic                 cfg_fast,
    input  logic                 cfg_incr,
    input  logic                 cfg_moto,
    input  logic                 cfg_use_rdy,
    input  logic                 rdy_in,
    input  logic [7:0]           ad_in,
    input  logic                 clr_flags,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [MXB_AW-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [MXB_DW-1:0]    rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 to_flag,
    output logic                 fe_flag
);
    localparam int IDX_W = MXB_LEN_W;

    mxb_state_e           state;
    mxb_req_t             req;
    logic [IDX_W-1:0]     idx;
    logic [2:0]           gcnt;
    logic [MXB_DW-1:0]    rdata_q;
    logic                 to_q, fe_q;

    logic                 rdy_s;
    logic                 legal;
    logic                 strb_last, ovf_evt;
    logic                 in_strb, last_byte, gap_end;
    logic [2:0]           glen;
    logic [MXB_AW-1:0]    cur_addr;
    logic [7:0]           cur_byte;

    mxb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (rdy_in),
        .q   (rdy_s)
    );

    mxb_req_check u_check (
        .lane  (req_addr[MXB_LANE_W-1:0]),
        .len   (req_len),
        .legal (legal)
    );

    mxb_strobe_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active    (in_strb),
        .limit     (cfg_timeout),
        .use_rdy   (cfg_use_rdy),
        .forced    (cfg_moto),
        .rdy_s     (rdy_s),
        .strb_last (strb_last),
        .ovf_evt   (ovf_evt)
    );

    always_comb begin
        in_strb   = (state == ST_STRB);
        last_byte = (idx == req.len - 1'b1);
        glen      = gap_cycles(cfg_incr, cfg_fast, req.wr);
        gap_end   = (gcnt == glen - 3'd1);
        cur_addr  = req.addr + {{(MXB_AW-IDX_W){1'b0}}, idx};
        cur_byte  = req.data[{idx[MXB_LANE_W-1:0], 3'b000} +: 8];
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req     <= '0;
            idx     <= '0;
            gcnt    <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && legal) begin
                        req.addr <= req_addr;
                        req.wr   <= req_wr;
                        req.len  <= req_len;
                        req.data <= req_wdata;
                        idx      <= '0;
                        rdata_q  <= '0;
                        state    <= ST_ALE;
                    end
                end
                ST_ALE:  state <= ST_ADDR;
                ST_ADDR: state <= ST_STRB;
                ST_STRB: begin
                    if (strb_last) begin
                        if (!req.wr)
                            rdata_q[{idx[MXB_LANE_W-1:0], 3'b000} +: 8] <= ad_in;
                        if (last_byte) begin
                            state <= ST_FIN;
                        end else begin
                            idx   <= idx + 1'b1;
                            gcnt  <= '0;
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_end) state <= cfg_incr ? ST_ALE : ST_STRB;
                    else         gcnt  <= gcnt + 3'd1;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky status; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            to_q <= 1'b0;
            fe_q <= 1'b0;
        end else begin
            if (ovf_evt)        to_q <= 1'b1;
            else if (clr_flags) to_q <= 1'b0;
            if (state == ST_IDLE && start && !legal) fe_q <= 1'b1;
            else if (clr_flags)                      fe_q <= 1'b0;
        end
    end

    // Bus outputs decoded from registered state
    always_comb begin
        ale    = (state == ST_ALE);
        rd_n   = !(in_strb && !req.wr);
        wr_n   = !(in_strb && req.wr);
        ad_oe  = (state == ST_ALE) || (state == ST_ADDR) || (in_strb && req.wr);
        if (state == ST_ALE || state == ST_ADDR) ad_out = cur_addr;
        else if (in_strb && req.wr)              ad_out = {8'h00, cur_byte};
        else                                     ad_out = '0;
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        rdata   = rdata_q;
        to_flag = to_q;
        fe_flag = fe_q;
    end
endmodule

// File: rtl/mxb_chk.sv
module mxb_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ad_oe,
    input logic             busy,
    input logic             done,
    input logic             to_flag,
    input logic             fe_flag,
    input logic             clr_flags,
    input logic [TMR_W-1:0] cfg_timeout,
    input logic             cfg_moto,
    input logic             cfg_use_rdy
);
    logic [TMR_W:0] low_run;
    logic           strobe;

    assign strobe = !rd_n || !wr_n;

    always_ff @(posedge clk) begin
        if (rst || !strobe)     low_run <= '0;
        else if (low_run != '1) low_run <= low_run + 1'b1;
    end

    a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));
    a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
        (rd_n || wr_n));
    a_r3_width_cap: assert property (@(posedge clk) disable iff (rst)
        (strobe && (cfg_moto || !cfg_use_rdy)) |-> (low_run <= {1'b0, cfg_timeout}));
    a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    a_r6_write_driven: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);
    a_r9_to_sticky: assert property (@(posedge clk) disable iff (rst)
        (to_flag && !clr_flags) |=> to_flag);
    a_r10_fe_sticky: assert property (@(posedge clk) disable iff (rst)
        (fe_flag && !clr_flags) |=> fe_flag);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind mxbus_cycle_ctrl mxb_chk #(.TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ad_oe       (ad_oe),
    .busy        (busy),
    .done        (done),
    .to_flag     (to_flag),
    .fe_flag     (fe_flag),
    .clr_flags   (clr_flags),
    .cfg_timeout (cfg_timeout),
    .cfg_moto    (cfg_moto),
    .cfg_use_rdy (cfg_use_rdy)
);

// File: tb/tb_mxbus_cycle_ctrl.sv
module tb_mxbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic [2:0]  req_len = 3'd1;
    logic [31:0] req_wdata = '0;
    logic [7:0]  cfg_timeout = '0;
    logic        cfg_fast = 1'b1, cfg_incr = 1'b0, cfg_moto = 1'b0, cfg_use_rdy = 1'b0;
    logic        rdy_in = 1'b1;
    logic [7:0]  ad_in = '0;
    logic        clr_flags = 1'b0;
    logic        ale, rd_n, wr_n, ad_oe, busy, done, to_flag, fe_flag;
    logic [15:0] ad_out;
    logic [31:0] rdata;

    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    mxbus_cycle_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_wr(req_wr),
        .req_len(req_len), .req_wdata(req_wdata), .cfg_timeout(cfg_timeout),
        .cfg_fast(cfg_fast), .cfg_incr(cfg_incr), .cfg_moto(cfg_moto),
        .cfg_use_rdy(cfg_use_rdy), .rdy_in(rdy_in), .ad_in(ad_in),
        .clr_flags(clr_flags), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .rdata(rdata), .busy(busy),
        .done(done), .to_flag(to_flag), .fe_flag(fe_flag)
    );

    // ---------------- bus monitor / target model ----------------
    int          xfer_id = 0, seen_id = 0;
    int          ale_cnt, st_cnt, done_cnt, run, hi_run, last_w;
    int          gap_min, gap_max, idle_min, idle_max, k;
    bit          prev_st, had_st;
    logic [15:0] addr_log [4];
    logic [7:0]  wb_log [4];
    logic [15:0] lat;

    always @(negedge clk) begin
        if (xfer_id != seen_id) begin
            seen_id = xfer_id;
            ale_cnt = 0; st_cnt = 0; done_cnt = 0; run = 0; hi_run = 0; last_w = 0;
            gap_min = 255; gap_max = 0; idle_min = 255; idle_max = 0; k = 0;
            prev_st = 0; had_st = 0; lat = '0;
            for (int i = 0; i < 4; i++) begin addr_log[i] = '0; wb_log[i] = '0; end
        end
        if (ale) begin
            if (had_st) begin
                if (hi_run < idle_min) idle_min = hi_run;
                if (hi_run > idle_max) idle_max = hi_run;
            end
            if (ale_cnt < 4) addr_log[ale_cnt] = ad_out;
            ale_cnt++;
            lat = ad_out;
            k = 0;
        end
        if (!rd_n || !wr_n) begin
            if (!prev_st) begin
                if (had_st) begin
                    if (hi_run < gap_min) gap_min = hi_run;
                    if (hi_run > gap_max) gap_max = hi_run;
                end
                if (st_cnt < 4 && !wr_n) wb_log[st_cnt] = ad_out[7:0];
                ad_in = (lat[7:0] + 8'(k)) ^ 8'hA5;
                run = 1;
            end else run++;
            prev_st = 1;
        end else begin
            if (prev_st) begin
                last_w = run; had_st = 1; st_cnt++; k++; hi_run = 1;
            end else hi_run++;
            prev_st = 0;
        end
        if (done) done_cnt++;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic kick(input logic [15:0] a, input logic w, input logic [2:0] n,
                        input logic [31:0] d);
        @(negedge clk);
        xfer_id++;
        req_addr = a; req_wr = w; req_len = n; req_wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 500) begin @(negedge clk); n++; end
        chk(done === 1'b1, "R11 done reached", {31'b0, done}, 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11 done one cycle",
            {30'b0, done, busy}, 0);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr_flags = 1'b1;
        @(negedge clk); clr_flags = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] t, input logic f, input logic inc,
                           input logic m, input logic ur);
        cfg_timeout = t; cfg_fast = f; cfg_incr = inc; cfg_moto = m; cfg_use_rdy = ur;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk({ale, rd_n, wr_n, ad_oe, busy, done, to_flag, fe_flag} === 8'b0110_0000,
            "R1 reset state", {24'b0, ale, rd_n, wr_n, ad_oe, busy, done, to_flag, fe_flag},
            32'h60);
    endtask

    task automatic t_shared_write_fast();
        set_cfg(8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        kick(16'h1230, 1'b1, 3'd4, 32'hDDCC_BBAA);
        chk(busy === 1'b1, "R11 busy after start", {31'b0, busy}, 1);
        wait_done();
        chk(ale_cnt == 1, "R4 single address phase", ale_cnt, 1);
        chk(addr_log[0] == 16'h1230, "R2 address on bus", addr_log[0], 16'h1230);
        chk(st_cnt == 4, "R4 strobe count", st_cnt, 4);
        chk(last_w == 1, "R3 width T=0", last_w, 1);
        chk(gap_min == 1 && gap_max == 1, "R4 fast gap", gap_max, 1);
        chk({wb_log[3], wb_log[2], wb_log[1], wb_log[0]} == 32'hDDCC_BBAA,
            "R6 write byte order", {wb_log[3], wb_log[2], wb_log[1], wb_log[0]}, 32'hDDCC_BBAA);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    endtask

    task automatic t_shared_read_slow();
        set_cfg(8'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        kick(16'h0042, 1'b0, 3'd2, 32'h0);
        wait_done();
        chk(ale_cnt == 1, "R4 single address phase read", ale_cnt, 1);
        chk(gap_min == 2 && gap_max == 2, "R4 slow gap", gap_max, 2);
        chk(last_w == 3, "R3 width T=2", last_w, 3);
        chk(rdata == 32'h0000_E6E7, "R6 read capture", rdata, 32'h0000_E6E7);
    endtask

    task automatic t_incr_write();
        set_cfg(8'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        kick(16'h2001, 1'b1, 3'd3, 32'h0033_2211);
        wait_done();
        chk(ale_cnt == 3, "R5 address per byte", ale_cnt, 3);
        chk(addr_log[0] == 16'h2001 && addr_log[1] == 16'h2002 && addr_log[2] == 16'h2003,
            "R5 address increments", addr_log[2], 16'h2003);
        chk(idle_min == 3 && idle_max == 3, "R5 write idle", idle_max, 3);
        chk(last_w == 2, "R3 width T=1", last_w, 2);
        chk({wb_log[2], wb_log[1], wb_log[0]} == 24'h332211, "R6 incremental bytes",
            {8'h0, wb_log[2], wb_log[1], wb_log[0]}, 32'h332211);
    endtask

    task automatic t_incr_read();
        set_cfg(8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(16'h4002, 1'b0, 3'd2, 32'h0);
        wait_done();
        chk(idle_min == 4 && idle_max == 4, "R5 read idle with fast set", idle_max, 4);
        chk(gap_min == 6, "R5 strobe spacing", gap_min, 6);
        chk(rdata == 32'h0000_A6A7, "R6 incremental read", rdata, 32'h0000_A6A7);
    endtask

    task automatic t_format();
        set_cfg(8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        kick(16'h0003, 1'b1, 3'd2, 32'h1);
        repeat (6) @(negedge clk);
        chk(fe_flag === 1'b1, "R10 crossing rejected", {31'b0, fe_flag}, 1);
        chk(ale_cnt == 0 && done_cnt == 0 && busy === 1'b0, "R10 no bus activity",
            ale_cnt + done_cnt, 0);
        pulse_clear();
        chk(fe_flag === 1'b0, "R10 clear", {31'b0, fe_flag}, 0);
        kick(16'h0010, 1'b1, 3'd0, 32'h1);
        @(negedge clk);
        chk(fe_flag === 1'b1, "R10 zero length", {31'b0, fe_flag}, 1);
        pulse_clear();
        kick(16'h0010, 1'b1, 3'd5, 32'h1);
        @(negedge clk);
        chk(fe_flag === 1'b1, "R10 length five", {31'b0, fe_flag}, 1);
        pulse_clear();
        kick(16'h0003, 1'b1, 3'd1, 32'h5A);
        wait_done();
        chk(fe_flag === 1'b0 && ale_cnt == 1, "R10 last lane accepted", ale_cnt, 1);
    endtask

    task automatic rdy_case(input logic [7:0] t, input int h, input int exp_w,
                            input logic exp_to);
        set_cfg(t, 1'b1, 1'b0, 1'b0, 1'b1);
        rdy_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clear();
        kick(16'h0010, 1'b0, 3'd1, 32'h0);
        while (rd_n) @(negedge clk);
        repeat (h) @(negedge clk);
        rdy_in = 1'b1;
        wait_done();
        chk(last_w == exp_w, "R7 ready stretched width", last_w, exp_w);
        chk(to_flag === exp_to, "R9 overflow flag", {31'b0, to_flag}, {31'b0, exp_to});
    endtask

    task automatic t_forced_end();
        set_cfg(8'd4, 1'b1, 1'b0, 1'b1, 1'b1);
        rdy_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clear();
        kick(16'h0020, 1'b1, 3'd1, 32'h77);
        wait_done();
        chk(last_w == 5, "R8 forced end width", last_w, 5);
        chk(to_flag === 1'b1, "R9 flag on forced end", {31'b0, to_flag}, 1);
        repeat (3) @(negedge clk);
        chk(to_flag === 1'b1, "R9 flag sticky", {31'b0, to_flag}, 1);
        pulse_clear();
        chk(to_flag === 1'b0, "R9 flag cleared", {31'b0, to_flag}, 0);
        rdy_in = 1'b1;
    endtask

    task automatic t_no_rdy_width();
        set_cfg(8'd5, 1'b1, 1'b0, 1'b1, 1'b0);
        rdy_in = 1'b0;
        repeat (4) @(negedge clk);
        kick(16'h0030, 1'b1, 3'd1, 32'h12);
        wait_done();
        chk(last_w == 6, "R3 width ignores ready", last_w, 6);
        chk(to_flag === 1'b0, "R3 no overflow", {31'b0, to_flag}, 0);
        rdy_in = 1'b1;
    endtask

    task automatic t_busy_ignore();
        set_cfg(8'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        kick(16'h0100, 1'b1, 3'd2, 32'h0000_BEEF);
        repeat (3) @(negedge clk);
        req_addr = 16'h7777; req_wdata = 32'h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        chk(ale_cnt == 1 && addr_log[0] == 16'h0100, "R12 start ignored",
            {ale_cnt[15:0], addr_log[0]}, {16'd1, 16'h0100});
        chk({wb_log[1], wb_log[0]} == 16'hBEEF && st_cnt == 2, "R12 data unchanged",
            {wb_log[1], wb_log[0]}, 16'hBEEF);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_shared_write_fast();
        t_shared_read_slow();
        t_incr_write();
        t_incr_read();
        t_format();
        rdy_case(8'd2, 5, 8, 1'b1);
        rdy_case(8'd2, 3, 6, 1'b1);
        rdy_case(8'd3, 3, 6, 1'b1);
        rdy_case(8'd6, 2, 7, 1'b0);
        t_forced_end();
        t_no_rdy_width();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule